// File: doc/BRIEF.md
# Privileged Performance Counter Bank

The block keeps a small set of 32-bit event counters. Each counter has two local control registers, and one global control register sits above all of them. Each counter watches one line of a 128-wide event vector and adds one on every clock in which that line is high. Software reaches every register through a numbered access port. The port has a move-to strobe for writes and a move-from strobe for reads. A mode input tells the block whether the access comes from supervisor or user code.

Supervisor code can read and write every register at its supervisor number. User code can only read, and only through alias numbers that sit 16 below the supervisor numbers. If user code touches a supervisor number, or anyone writes an alias, the block raises a one-cycle exception pulse and changes nothing. The block has one level-sensitive interrupt request. An outside prioritiser ranks it below the fixed-interval interrupt and above the decrementer. The request is raised while an enabled counter has its top bit set. The block can also freeze every counter by itself the moment that condition appears.

Top module: `pmu_bank`

## Requirements
- R1: Supervisor numbers: counters are 16..19, local control A is 144..147, local control B is 272..275 and global control is 400. In supervisor mode a move-to writes the register and a move-from reads it.
- R2: `rd_data` takes its new value on the clock edge that samples `mf_strobe` and holds it until the next read.
- R3: The number minus 16 is a read-only alias of the same register. Aliases are 0..3, 128..131, 256..259 and 384, and they can be read in either mode.
- R4: A move-to aimed at an alias number changes no state and pulses `priv_exc` high for exactly one cycle, in either mode.
- R5: In user mode, any access to a supervisor number changes no state, pulses `priv_exc` for one cycle and, for a read, returns zero.
- R6: Local control A holds the event select in bits [6:0]. The counter adds one on each clock edge at which its selected event line is high and it is not blocked.
- R7: A counter wraps from 0xFFFFFFFF to 0. A counter write in the same cycle as an event wins over the increment.
- R8: Local control A bit 17 freezes that one counter.
- R9: Global control bit 0 freezes every counter, whatever the local settings.
- R10: Local control B bit 0 blocks counting while `user_mode` is 1, and bit 1 blocks counting while it is 0. Its other bits read as zero.
- R11: `irq` is high exactly when global bit 1 is set and at least one counter has local control A bit 16 set together with counter bit 31.
- R12: When global bit 2 is set, hardware sets global bit 0 on the edge after `irq` goes high.
- R13: A read of an undefined number returns zero. A write to an undefined number is ignored. Neither raises `priv_exc`.
- R14: After reset, every register, `rd_data`, `irq` and `priv_exc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| reg_num | input | 10 | Register number for the access |
| mt_strobe | input | 1 | Move-to (write) request |
| mf_strobe | input | 1 | Move-from (read) request |
| wr_data | input | 32 | Write data |
| events | input | 128 | Event lines |
| rd_data | output | 32 | Registered read data |
| priv_exc | output | 1 | One-cycle privilege exception pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The step and freeze assertions assume that a counter write is the only way its value can jump. They also assume that the event lines and the mode only change between edges. The bench always drives these inputs on the falling edge.

The freeze-on-alert assertion assumes software does not write the global register in the same cycle that the alert appears. The bench always lets writes settle before it raises an event that could cross bit 31.

The exception assertion assumes the two strobes are never high together. Every access task in the bench raises exactly one strobe at a time.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int DATA_W    = 32;
    localparam int EVT_SEL_W = 7;
    localparam int NUM_EVT   = 1 << EVT_SEL_W;
    localparam int REGNUM_W  = 10;
    localparam int IDX_W     = 4;

    localparam int LCA_IE_BIT  = 16;
    localparam int LCA_FRZ_BIT = 17;

    typedef enum logic [1:0] {
        GRP_CTR = 2'd0,
        GRP_LCA = 2'd1,
        GRP_LCB = 2'd2,
        GRP_GLB = 2'd3
    } grp_e;

    typedef struct packed {
        logic                 frz;
        logic                 ie;
        logic [EVT_SEL_W-1:0] sel;
    } lca_t;

    typedef struct packed {
        logic no_sup;
        logic no_user;
    } lcb_t;

    typedef struct packed {
        logic foa;
        logic gie;
        logic frz_all;
    } glb_t;

    typedef struct packed {
        logic             hit;
        logic             sup;
        grp_e             grp;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic [DATA_W-1:0] lca_word(lca_t a);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EVT_SEL_W-1:0] = a.sel;
        w[LCA_IE_BIT]    = a.ie;
        w[LCA_FRZ_BIT]   = a.frz;
        return w;
    endfunction

    function automatic lca_t word_lca(logic [DATA_W-1:0] w);
        lca_t a;
        a.sel = w[EVT_SEL_W-1:0];
        a.ie  = w[LCA_IE_BIT];
        a.frz = w[LCA_FRZ_BIT];
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] lcb_word(lcb_t b);
        return {{(DATA_W-2){1'b0}}, b.no_sup, b.no_user};
    endfunction

    function automatic lcb_t word_lcb(logic [DATA_W-1:0] w);
        lcb_t b;
        b.no_user = w[0];
        b.no_sup  = w[1];
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] glb_word(glb_t g);
        return {{(DATA_W-3){1'b0}}, g.foa, g.gie, g.frz_all};
    endfunction

    function automatic glb_t word_glb(logic [DATA_W-1:0] w);
        glb_t g;
        g.frz_all = w[0];
        g.gie     = w[1];
        g.foa     = w[2];
        return g;
    endfunction

endpackage

// File: rtl/pmu_regdec.sv
module pmu_regdec
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic [REGNUM_W-1:0] reg_num,
    input  logic                mt_strobe,
    input  logic                mf_strobe,
    input  logic                user_mode,
    output dec_t                dec,
    output logic                wr_ok,
    output logic                rd_ok,
    output logic                fault
);

    localparam logic [IDX_W:0] NCTR = (IDX_W+1)'(NUM_CTR);

    logic idx_ok;

    always_comb begin
        dec.grp = grp_e'(reg_num[8:7]);
        dec.sup = reg_num[4];
        dec.idx = reg_num[IDX_W-1:0];
        if (dec.grp == GRP_GLB) begin
            idx_ok = (dec.idx == '0);
        end else begin
            idx_ok = ({1'b0, dec.idx} < NCTR);
        end
        dec.hit = !reg_num[9] && (reg_num[6:5] == 2'b00) && idx_ok;
    end

    assign fault = dec.hit && (mt_strobe || mf_strobe) &&
                   ((dec.sup && user_mode) || (!dec.sup && mt_strobe));
    assign wr_ok = dec.hit && mt_strobe && dec.sup && !user_mode;
    assign rd_ok = dec.hit && mf_strobe && !(dec.sup && user_mode);

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] events,
    input  logic               user_mode,
    input  logic               frz_all,
    input  logic               cnt_we,
    input  logic               lca_we,
    input  logic               lcb_we,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  cnt,
    output lca_t               lca,
    output lcb_t               lcb,
    output logic               alert
);

    logic blocked;
    logic run;

    assign blocked = user_mode ? lcb.no_user : lcb.no_sup;
    assign run     = !frz_all && !lca.frz && !blocked && events[lca.sel];
    assign alert   = lca.ie && cnt[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lca <= '0;
            lcb <= '0;
        end else begin
            if (lca_we) lca <= word_lca(wr_data);
            if (lcb_we) lcb <= word_lcb(wr_data);
            if (cnt_we) begin
                cnt <= wr_data;
            end else if (run) begin
                cnt <= cnt + DATA_W'(1);
            end
        end
    end

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> (cnt == $past(cnt) || cnt == $past(cnt) + DATA_W'(1))); // R6

    AST_CTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((frz_all || lca.frz) && !cnt_we) |=> $stable(cnt)); // R9

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!lca_we && !lcb_we) |=> ($stable(lca) && $stable(lcb))); // R4

endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                user_mode,
    input  logic [REGNUM_W-1:0] reg_num,
    input  logic                mt_strobe,
    input  logic                mf_strobe,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_EVT-1:0]  events,
    output logic [DATA_W-1:0]   rd_data,
    output logic                priv_exc,
    output logic                irq
);

    dec_t              dec;
    logic              wr_ok, rd_ok, fault;
    glb_t              glb_q;
    logic              glb_we;
    logic [DATA_W-1:0] cnt_q [NUM_CTR];
    lca_t              lca_q [NUM_CTR];
    lcb_t              lcb_q [NUM_CTR];
    logic [NUM_CTR-1:0] alert;
    logic [DATA_W-1:0] rd_word;

    pmu_regdec #(.NUM_CTR(NUM_CTR)) u_dec (
        .reg_num   (reg_num),
        .mt_strobe (mt_strobe),
        .mf_strobe (mf_strobe),
        .user_mode (user_mode),
        .dec       (dec),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .fault     (fault)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic sel_me;
        assign sel_me = wr_ok && (dec.idx == IDX_W'(i));

        pmu_counter u_ctr (
            .clk       (clk),
            .rst       (rst),
            .events    (events),
            .user_mode (user_mode),
            .frz_all   (glb_q.frz_all),
            .cnt_we    (sel_me && dec.grp == GRP_CTR),
            .lca_we    (sel_me && dec.grp == GRP_LCA),
            .lcb_we    (sel_me && dec.grp == GRP_LCB),
            .wr_data   (wr_data),
            .cnt       (cnt_q[i]),
            .lca       (lca_q[i]),
            .lcb       (lcb_q[i]),
            .alert     (alert[i])
        );
    end

    assign glb_we = wr_ok && dec.grp == GRP_GLB;
    assign irq    = glb_q.gie && (|alert);

    always_comb begin
        rd_word = '0;
        if (dec.grp == GRP_GLB) begin
            rd_word = glb_word(glb_q);
        end else begin
            for (int i = 0; i < NUM_CTR; i++) begin
                if (dec.idx == IDX_W'(i)) begin
                    case (dec.grp)
                        GRP_CTR: rd_word = cnt_q[i];
                        GRP_LCA: rd_word = lca_word(lca_q[i]);
                        GRP_LCB: rd_word = lcb_word(lcb_q[i]);
                        default: rd_word = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            priv_exc <= 1'b0;
            glb_q    <= '0;
        end else begin
            priv_exc <= fault;
            if (mf_strobe) begin
                rd_data <= rd_ok ? rd_word : '0;
            end
            if (glb_we) begin
                glb_q <= word_glb(wr_data);
            end else if (glb_q.foa && irq) begin
                glb_q.frz_all <= 1'b1;
            end
        end
    end

    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        priv_exc |-> $past(mt_strobe || (mf_strobe && user_mode))); // R5

    AST_FOA_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (glb_q.foa && irq && !glb_we) |=> glb_q.frz_all); // R12

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mf_strobe && !dec.hit) |=> (rd_data == '0 && !priv_exc)); // R13

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mf_strobe |=> $stable(rd_data)); // R2

endmodule

// File: tb/tb_pmu_bank.sv
module tb_pmu_bank;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         user_mode = 1'b0;
    logic [9:0]   reg_num = '0;
    logic         mt_strobe = 1'b0;
    logic         mf_strobe = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [127:0] events = '0;
    logic [31:0]  rd_data;
    logic         priv_exc;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] got;

    always #4 clk = ~clk;

    pmu_bank dut (
        .clk       (clk),
        .rst       (rst),
        .user_mode (user_mode),
        .reg_num   (reg_num),
        .mt_strobe (mt_strobe),
        .mf_strobe (mf_strobe),
        .wr_data   (wr_data),
        .events    (events),
        .rd_data   (rd_data),
        .priv_exc  (priv_exc),
        .irq       (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] n, input logic [31:0] d, output logic exc);
        @(negedge clk);
        reg_num = n; wr_data = d; mt_strobe = 1'b1;
        @(negedge clk);
        mt_strobe = 1'b0;
        exc = priv_exc;
        @(negedge clk);
        if (priv_exc !== 1'b0) begin
            n_checks++; n_fail++;
            $display("FAIL R4: exception pulse longer than one cycle, actual 1 expected 0");
        end
    endtask

    task automatic rd(input logic [9:0] n, output logic [31:0] d, output logic exc);
        @(negedge clk);
        reg_num = n; mf_strobe = 1'b1;
        @(negedge clk);
        mf_strobe = 1'b0;
        d = rd_data;
        exc = priv_exc;
    endtask

    task automatic pulse_events(input logic [127:0] mask, input int cycles);
        @(negedge clk);
        events = mask;
        repeat (cycles) @(negedge clk);
        events = '0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic t_reset();
        logic e;
        for (int i = 0; i < 4; i++) begin
            rd(10'(16 + i), got, e); check("R14 counter", got, 0);
            rd(10'(144 + i), got, e); check("R14 lca", got, 0);
        end
        rd(10'd400, got, e); check("R14 global", got, 0);
        check("R14 irq", {31'b0, irq}, 0);
        check("R14 priv_exc", {31'b0, priv_exc}, 0);
    endtask

    task automatic t_map();
        logic e;
        wr(10'd17, 32'hCAFE_0001, e); check("R1 write exc", {31'b0, e}, 0);
        rd(10'd17, got, e); check("R1 counter1", got, 32'hCAFE_0001);
        wr(10'd146, 32'hFFFF_FFFF, e);
        rd(10'd146, got, e); check("R1 lca2 fields", got, 32'h0003_007F);
        wr(10'd275, 32'hFFFF_FFFF, e);
        rd(10'd275, got, e); check("R10 lcb3 fields", got, 32'h3);
        wr(10'd146, 0, e); wr(10'd275, 0, e);
        // R2: rd_data holds after read with no new strobe
        repeat (3) @(negedge clk);
        check("R2 hold", rd_data, 32'h3);
    endtask

    task automatic t_alias();
        logic e;
        user_mode = 1'b1;
        rd(10'd1, got, e);
        check("R3 user alias ctr", got, 32'hCAFE_0001);
        check("R3 no exc", {31'b0, e}, 0);
        user_mode = 1'b0;
        rd(10'd1, got, e); check("R3 sup alias ctr", got, 32'hCAFE_0001);
        wr(10'd1, 32'h1234, e);
        check("R4 alias write exc", {31'b0, e}, 1);
        rd(10'd17, got, e); check("R4 unchanged", got, 32'hCAFE_0001);
        user_mode = 1'b1;
        wr(10'd384, 32'h7, e); check("R4 user alias write exc", {31'b0, e}, 1);
        user_mode = 1'b0;
        rd(10'd400, got, e); check("R4 global unchanged", got, 0);
    endtask

    task automatic t_user_fault();
        logic e;
        user_mode = 1'b1;
        wr(10'd17, 32'h5555, e); check("R5 user write exc", {31'b0, e}, 1);
        rd(10'd17, got, e);
        check("R5 user read exc", {31'b0, e}, 1);
        check("R5 user read zero", got, 0);
        user_mode = 1'b0;
        rd(10'd17, got, e); check("R5 unchanged", got, 32'hCAFE_0001);
    endtask

    task automatic t_count();
        logic e;
        logic [127:0] m;
        wr(10'd144, 32'h7F, e);
        wr(10'd145, 32'h00, e);
        wr(10'd16, 0, e);
        wr(10'd17, 0, e);
        m = '0; m[127] = 1'b1; m[0] = 1'b1;
        pulse_events(m, 3);
        m[0] = 1'b0;
        pulse_events(m, 2);
        rd(10'd16, got, e); check("R6 ctr0 sel 127", got, 5);
        rd(10'd17, got, e); check("R6 ctr1 sel 0", got, 3);
        wr(10'd16, 32'hFFFF_FFFF, e);
        pulse_events(m, 1);
        rd(10'd16, got, e); check("R7 wrap", got, 0);
    endtask

    task automatic t_freeze();
        logic e;
        logic [127:0] m;
        wr(10'd147, 32'h0002_0014, e);
        wr(10'd19, 9, e);
        m = '0; m[20] = 1'b1;
        pulse_events(m, 4);
        rd(10'd19, got, e); check("R8 local freeze", got, 9);
        wr(10'd16, 0, e);
        wr(10'd400, 32'h1, e);
        m = '0; m[127] = 1'b1;
        pulse_events(m, 4);
        rd(10'd16, got, e); check("R9 global freeze", got, 0);
        wr(10'd400, 32'h0, e);
        pulse_events(m, 4);
        rd(10'd16, got, e); check("R9 released", got, 4);
    endtask

    task automatic t_mode();
        logic e;
        logic [127:0] m;
        wr(10'd17, 0, e);
        wr(10'd273, 32'h1, e);
        m = '0; m[0] = 1'b1;
        @(negedge clk); user_mode = 1'b1;
        pulse_events(m, 3);
        @(negedge clk); user_mode = 1'b0;
        pulse_events(m, 2);
        rd(10'd17, got, e); check("R10 no_user", got, 2);
        wr(10'd273, 32'h2, e);
        pulse_events(m, 2);
        @(negedge clk); user_mode = 1'b1;
        pulse_events(m, 3);
        @(negedge clk); user_mode = 1'b0;
        rd(10'd17, got, e); check("R10 no_sup", got, 5);
        wr(10'd273, 0, e);
    endtask

    task automatic t_irq();
        logic e;
        logic [127:0] m;
        wr(10'd146, 32'h0001_0003, e);
        wr(10'd18, 32'h7FFF_FFFF, e);
        wr(10'd400, 32'h2, e);
        check("R11 irq low below msb", {31'b0, irq}, 0);
        m = '0; m[3] = 1'b1;
        pulse_events(m, 1);
        check("R11 irq high", {31'b0, irq}, 1);
        wr(10'd400, 32'h0, e);
        check("R11 gie off", {31'b0, irq}, 0);
        wr(10'd400, 32'h2, e);
        wr(10'd146, 32'h0000_0003, e);
        check("R11 ie off", {31'b0, irq}, 0);
        wr(10'd146, 32'h0001_0003, e);
        wr(10'd18, 32'h7FFF_FFFF, e);
        wr(10'd400, 32'h6, e);
        pulse_events(m, 3);
        rd(10'd400, got, e); check("R12 freeze set", got, 32'h7);
        rd(10'd18, got, e); check("R12 counter stopped", got, 32'h8000_0001);
        check("R12 irq stays", {31'b0, irq}, 1);
        wr(10'd400, 32'h0, e);
    endtask

    task automatic t_undef();
        logic e;
        rd(10'd17, got, e);
        rd(10'd5, got, e);
        check("R13 undef read zero", got, 0);
        check("R13 undef read no exc", {31'b0, e}, 0);
        rd(10'd600, got, e); check("R13 undef 600", got, 0);
        wr(10'd20, 32'hDEAD, e);
        check("R13 undef write no exc", {31'b0, e}, 0);
        for (int i = 0; i < 4; i++) begin
            rd(10'(144 + i), got, e);
            if (i == 2) check("R13 lca2 untouched", got, 32'h0001_0003);
        end
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_alias();
        t_user_fault();
        t_count();
        t_freeze();
        t_mode();
        t_irq();
        t_undef();
        finish_up();
    end

endmodule